// File: doc/BRIEF.md
# Delayed Transaction Completion Tracker

This block tracks one delayed transaction inside a bus bridge. When an initiator first presents a request, the tracker stores the address, command, byte enables and write word. It answers that attempt with retry and raises a request for the far side of the bridge to run the transaction on the target bus. While the target-side run is still going, every initiator attempt is answered with retry. Target-side retry or disconnect without data makes the tracker repeat the run. A data transfer, a master abort or a target abort ends it.

After completion the tracker holds the outcome and, for reads, one data word. The next initiator attempt whose address, command and byte enables match the stored request is completed with TRDY, or with target abort if the target aborted. Attempts that do not match are retried and leave the stored completion untouched. If the initiator does not return within a fixed window of clocks, the completion is dropped and a discard status bit is set. Three sticky status bits report abort and discard events and are cleared by writing 1.

The attempt and response pins form a per-attempt handshake rather than a stream. An attempt is a one-clock strobe and always receives exactly one response one clock later, so the initiator side never applies back-pressure. The target-side events are single-clock pulses that are accepted only while the request is raised.

Top module: `dtx_tracker`

## Requirements
- R1: After reset, `tgt_req`, all three response outputs and all status bits are 0.
- R2: An attempt while the tracker is idle stores the request. On the next clock `ini_retry` is 1, `tgt_req` is 1, and `tgt_addr`/`tgt_cmd`/`tgt_be`/`tgt_wdata` show the stored values.
- R3: While `tgt_req` is 1, every attempt, matching or not, is answered with `ini_retry`, and the stored request does not change.
- R4: `tgt_retry` or `tgt_disc` without a completing event leaves `tgt_req` at 1, so the target-side run is repeated.
- R5: `tgt_xfer` while `tgt_req` is 1 ends the run, and `tgt_req` is 0 on the next clock. For a read command (`cmd[0]`=0) `tgt_rdata` is captured and shown on `ini_rdata`.
- R6: `tgt_mabort` ends the run. The next matching attempt is answered with `ini_trdy`, and for a read `ini_rdata` is all ones.
- R7: `tgt_tabort` ends the run and sets `sts[0]` (received target abort, target interface) on the next clock. The next matching attempt is answered with `ini_tabort` and sets `sts[1]` (signaled target abort, initiator interface).
- R8: After completion, an attempt that differs in address, command or byte enables is answered with `ini_retry`, and the stored completion is kept.
- R9: A matching attempt after completion gets its response on the next clock and returns the tracker to idle. The next attempt then starts a new request.
- R10: If no matching attempt arrives within 2^DISC_W clocks after completion, the entry is dropped, `sts[2]` (discard) is set, and a later repeat is handled as a new request.
- R11: Status bits are sticky. A 1 in `sts_clr` clears the bit on the next clock, and a set in the same clock wins over the clear.
- R12: Each attempt produces exactly one of `ini_retry`, `ini_trdy`, `ini_tabort` for one clock, one clock later. No response appears without an attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_attempt | input | 1 | Initiator attempt strobe |
| ini_addr | input | AW | Attempt address |
| ini_cmd | input | 4 | Attempt command, bit 0 = 0 means read |
| ini_be | input | 4 | Attempt byte enables |
| ini_wdata | input | DW | Attempt write word |
| ini_retry | output | 1 | Retry response |
| ini_trdy | output | 1 | Completion response |
| ini_tabort | output | 1 | Target-abort response |
| ini_rdata | output | DW | Held read word |
| tgt_req | output | 1 | Run the stored request on the target bus |
| tgt_addr | output | AW | Stored address |
| tgt_cmd | output | 4 | Stored command |
| tgt_be | output | 4 | Stored byte enables |
| tgt_wdata | output | DW | Stored write word |
| tgt_xfer | input | 1 | Target side transferred a word |
| tgt_rdata | input | DW | Word read on the target side |
| tgt_mabort | input | 1 | Target side master abort |
| tgt_tabort | input | 1 | Target side target abort |
| tgt_retry | input | 1 | Target side retry |
| tgt_disc | input | 1 | Target side disconnect without data |
| sts | output | 3 | Sticky status: [0] rx target abort, [1] signaled target abort, [2] discard |
| sts_clr | input | 3 | Write-1-to-clear for `sts` |

## Verification
Every result of this block arrives one clock after its cause. This covers the response pulse after an attempt, `tgt_req` after an attempt or a completing event, and a status bit after its setting event or clear. The only exception is the discard bit, which appears exactly 2^DISC_W clocks after the completing event. The bench drives inputs on the falling edge and samples on the following falling edge, which is one rising edge later. For the discard window it samples both one clock before and at the expiry edge, so that a timer that is off by one is caught.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_DONE = 2'd2
  } dtx_state_e;

  typedef enum logic [1:0] {
    OC_DATA   = 2'd0,
    OC_MABORT = 2'd1,
    OC_TABORT = 2'd2
  } dtx_outcome_e;

  localparam int STS_W       = 3;
  localparam int STS_RX_TAB  = 0;
  localparam int STS_SIG_TAB = 1;
  localparam int STS_DISCARD = 2;

  function automatic logic cmd_is_read(input logic [3:0] cmd);
    return ~cmd[0];
  endfunction
endpackage

// File: rtl/dtx_req_hold.sv
module dtx_req_hold #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic [3:0]    in_cmd,
  input  logic [3:0]    in_be,
  input  logic [DW-1:0] in_wdata,
  output logic [AW-1:0] hold_addr,
  output logic [3:0]    hold_cmd,
  output logic [3:0]    hold_be,
  output logic [DW-1:0] hold_wdata,
  output logic          match
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_addr  <= '0;
      hold_cmd   <= '0;
      hold_be    <= '0;
      hold_wdata <= '0;
    end else if (load) begin
      hold_addr  <= in_addr;
      hold_cmd   <= in_cmd;
      hold_be    <= in_be;
      hold_wdata <= in_wdata;
    end
  end

  assign match = (in_addr == hold_addr) && (in_cmd == hold_cmd) && (in_be == hold_be);

  // R3: the stored request only changes when the controller loads it
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable({hold_addr, hold_cmd, hold_be, hold_wdata}));
endmodule

// File: rtl/dtx_discard_timer.sv
module dtx_discard_timer #(
  parameter int CW = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (!expire)   cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CNT_MAX);

  // R10: the window advances by one per clock while the completion waits
  assert_window_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expire) |=> (!run || (cnt == $past(cnt) + 1'b1)));
endmodule

// File: rtl/dtx_status.sv
module dtx_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)      sts[i] <= 1'b0;
      else if (set[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end
  end

  // R11: a bit holds unless cleared, and a set always lands
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts & $past(sts & ~clr)) == $past(sts & ~clr)) && ((sts & $past(set)) == $past(set)));
endmodule

// File: rtl/dtx_ctrl.sv
module dtx_ctrl
  import dtx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          attempt,
  input  logic          match,
  input  logic [3:0]    hold_cmd,
  input  logic          ev_xfer,
  input  logic [DW-1:0] ev_rdata,
  input  logic          ev_mabort,
  input  logic          ev_tabort,
  input  logic          ev_retry,
  input  logic          ev_disc,
  input  logic          expire,
  output dtx_state_e    state,
  output logic          load,
  output logic          timer_run,
  output logic          resp_retry,
  output logic          resp_trdy,
  output logic          resp_tabort,
  output logic [DW-1:0] rdata,
  output logic          set_rx_tab,
  output logic          set_sig_tab,
  output logic          set_discard
);
  dtx_outcome_e outcome;
  logic         pend, done, hit, ends_run;

  assign pend      = (state == ST_PEND);
  assign done      = (state == ST_DONE);
  assign hit       = done && attempt && match;
  assign ends_run  = pend && (ev_xfer || ev_mabort || ev_tabort);
  assign load      = (state == ST_IDLE) && attempt;
  assign timer_run = done;

  assign set_rx_tab  = pend && ev_tabort;
  assign set_sig_tab = hit && (outcome == OC_TABORT);
  assign set_discard = expire && !hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (attempt)                  state <= ST_PEND;
        ST_PEND: if (ends_run)                 state <= ST_DONE;
        ST_DONE: if (hit || expire)            state <= ST_IDLE;
        default:                               state <= ST_IDLE;
      endcase
    end
  end

  // outcome and captured read word; aborts outrank a data event in the same clock
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outcome <= OC_DATA;
      rdata   <= '0;
    end else if (pend) begin
      if (ev_tabort) begin
        outcome <= OC_TABORT;
      end else if (ev_mabort) begin
        outcome <= OC_MABORT;
        if (cmd_is_read(hold_cmd)) rdata <= '1;
      end else if (ev_xfer) begin
        outcome <= OC_DATA;
        if (cmd_is_read(hold_cmd)) rdata <= ev_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_retry  <= 1'b0;
      resp_trdy   <= 1'b0;
      resp_tabort <= 1'b0;
    end else begin
      resp_retry  <= attempt && !hit;
      resp_trdy   <= hit && (outcome != OC_TABORT);
      resp_tabort <= hit && (outcome == OC_TABORT);
    end
  end

  // R12: at most one response, and only after an attempt
  assert_one_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resp_retry, resp_trdy, resp_tabort}));
  assert_resp_needs_attempt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !attempt |=> !(resp_retry || resp_trdy || resp_tabort));
  // R3: attempts during the target-side run are retried
  assert_pend_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && attempt) |=> resp_retry);
  // R4: retry or disconnect alone keeps the run going
  assert_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && (ev_retry || ev_disc) && !ev_xfer && !ev_mabort && !ev_tabort) |=> (state == ST_PEND));
  // R5: a transfer completes the run
  assert_xfer_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && ev_xfer) |=> (state == ST_DONE));
  // R9: a matching attempt finishes the entry
  assert_hit_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && attempt && match) |=> ((state == ST_IDLE) && (resp_trdy || resp_tabort)));
  // R8: non-matching attempts after completion keep the entry
  assert_miss_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && attempt && !match && !expire) |=> ((state == ST_DONE) && resp_retry));
endmodule

// File: rtl/dtx_tracker.sv
module dtx_tracker
  import dtx_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int DISC_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ini_attempt,
  input  logic [AW-1:0]    ini_addr,
  input  logic [3:0]       ini_cmd,
  input  logic [3:0]       ini_be,
  input  logic [DW-1:0]    ini_wdata,
  output logic             ini_retry,
  output logic             ini_trdy,
  output logic             ini_tabort,
  output logic [DW-1:0]    ini_rdata,
  output logic             tgt_req,
  output logic [AW-1:0]    tgt_addr,
  output logic [3:0]       tgt_cmd,
  output logic [3:0]       tgt_be,
  output logic [DW-1:0]    tgt_wdata,
  input  logic             tgt_xfer,
  input  logic [DW-1:0]    tgt_rdata,
  input  logic             tgt_mabort,
  input  logic             tgt_tabort,
  input  logic             tgt_retry,
  input  logic             tgt_disc,
  output logic [STS_W-1:0] sts,
  input  logic [STS_W-1:0] sts_clr
);
  dtx_state_e       state;
  logic             load, match, expire, timer_run;
  logic             set_rx_tab, set_sig_tab, set_discard;
  logic [STS_W-1:0] sts_set;

  dtx_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_addr(ini_addr), .in_cmd(ini_cmd), .in_be(ini_be), .in_wdata(ini_wdata),
    .hold_addr(tgt_addr), .hold_cmd(tgt_cmd), .hold_be(tgt_be), .hold_wdata(tgt_wdata),
    .match(match)
  );

  dtx_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .attempt(ini_attempt), .match(match), .hold_cmd(tgt_cmd),
    .ev_xfer(tgt_xfer), .ev_rdata(tgt_rdata), .ev_mabort(tgt_mabort), .ev_tabort(tgt_tabort),
    .ev_retry(tgt_retry), .ev_disc(tgt_disc), .expire(expire),
    .state(state), .load(load), .timer_run(timer_run),
    .resp_retry(ini_retry), .resp_trdy(ini_trdy), .resp_tabort(ini_tabort), .rdata(ini_rdata),
    .set_rx_tab(set_rx_tab), .set_sig_tab(set_sig_tab), .set_discard(set_discard)
  );

  dtx_discard_timer #(.CW(DISC_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .expire(expire)
  );

  always_comb begin
    sts_set              = '0;
    sts_set[STS_RX_TAB]  = set_rx_tab;
    sts_set[STS_SIG_TAB] = set_sig_tab;
    sts_set[STS_DISCARD] = set_discard;
  end

  dtx_status #(.N(STS_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr), .sts(sts)
  );

  assign tgt_req = (state == ST_PEND);

  // R7: a target abort during the run is recorded on the target-side bit
  assert_rx_tab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && tgt_tabort) |=> sts[STS_RX_TAB]);
  // R2: an idle attempt raises the target request
  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && ini_attempt) |=> (tgt_req && ini_retry));
endmodule

// File: tb/sim_dtx_tracker.sv
module sim_dtx_tracker;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int DISC_W = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ini_attempt = 1'b0;
  logic [AW-1:0] ini_addr = '0;
  logic [3:0] ini_cmd = '0, ini_be = '0;
  logic [DW-1:0] ini_wdata = '0;
  logic ini_retry, ini_trdy, ini_tabort;
  logic [DW-1:0] ini_rdata;
  logic tgt_req;
  logic [AW-1:0] tgt_addr;
  logic [3:0] tgt_cmd, tgt_be;
  logic [DW-1:0] tgt_wdata;
  logic tgt_xfer = 1'b0, tgt_mabort = 1'b0, tgt_tabort = 1'b0, tgt_retry = 1'b0, tgt_disc = 1'b0;
  logic [DW-1:0] tgt_rdata = '0;
  logic [2:0] sts;
  logic [2:0] sts_clr = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dtx_tracker #(.AW(AW), .DW(DW), .DISC_W(DISC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .ini_attempt(ini_attempt), .ini_addr(ini_addr),
    .ini_cmd(ini_cmd), .ini_be(ini_be), .ini_wdata(ini_wdata),
    .ini_retry(ini_retry), .ini_trdy(ini_trdy), .ini_tabort(ini_tabort), .ini_rdata(ini_rdata),
    .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_cmd(tgt_cmd), .tgt_be(tgt_be),
    .tgt_wdata(tgt_wdata), .tgt_xfer(tgt_xfer), .tgt_rdata(tgt_rdata),
    .tgt_mabort(tgt_mabort), .tgt_tabort(tgt_tabort), .tgt_retry(tgt_retry),
    .tgt_disc(tgt_disc), .sts(sts), .sts_clr(sts_clr)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one attempt; returns {tabort,trdy,retry} one clock later
  task automatic attempt(input logic [AW-1:0] a, input logic [3:0] c, input logic [3:0] b,
                         input logic [DW-1:0] w, output logic [2:0] resp);
    @(negedge clk);
    ini_attempt = 1'b1; ini_addr = a; ini_cmd = c; ini_be = b; ini_wdata = w;
    @(negedge clk);
    ini_attempt = 1'b0;
    resp = {ini_tabort, ini_trdy, ini_retry};
  endtask

  // kind: 0 xfer, 1 mabort, 2 tabort, 3 retry, 4 disc
  task automatic tevent(input int kind, input logic [DW-1:0] d, input logic [2:0] clr);
    @(negedge clk);
    tgt_xfer = (kind == 0); tgt_mabort = (kind == 1); tgt_tabort = (kind == 2);
    tgt_retry = (kind == 3); tgt_disc = (kind == 4); tgt_rdata = d; sts_clr = clr;
    @(negedge clk);
    tgt_xfer = 0; tgt_mabort = 0; tgt_tabort = 0; tgt_retry = 0; tgt_disc = 0; sts_clr = '0;
  endtask

  task automatic clear_sts(input logic [2:0] clr);
    @(negedge clk); sts_clr = clr;
    @(negedge clk); sts_clr = '0;
  endtask

  task automatic t_reset();
    check("R1 tgt_req", tgt_req, 0);
    check("R1 resp", {ini_tabort, ini_trdy, ini_retry}, 0);
    check("R1 sts", sts, 0);
    @(negedge clk);
    check("R12 no resp idle", {ini_tabort, ini_trdy, ini_retry}, 0);
  endtask

  task automatic t_read_xfer();
    logic [2:0] r;
    attempt(32'h1000_0040, 4'b0110, 4'hF, '0, r);
    check("R2 retry", r, 3'b001);
    check("R2 tgt_req", tgt_req, 1);
    check("R2 tgt_addr", tgt_addr, 32'h1000_0040);
    check("R2 tgt_cmd/be", {tgt_cmd, tgt_be}, 8'h6F);
    attempt(32'h2000_0000, 4'b0110, 4'hF, '0, r);
    check("R3 miss retried", r, 3'b001);
    attempt(32'h1000_0040, 4'b0110, 4'hF, '0, r);
    check("R3 match retried", r, 3'b001);
    check("R3 hold kept", tgt_addr, 32'h1000_0040);
    tevent(3, '0, '0);
    check("R4 repeat after retry", tgt_req, 1);
    tevent(4, '0, '0);
    check("R4 repeat after disc", tgt_req, 1);
    tevent(0, 32'hCAFE_1234, '0);
    check("R5 req drops", tgt_req, 0);
    check("R5 rdata", ini_rdata, 32'hCAFE_1234);
    attempt(32'h1000_0040, 4'b0110, 4'h3, '0, r);
    check("R8 be mismatch retried", r, 3'b001);
    check("R8 no new run", tgt_req, 0);
    attempt(32'h1000_0040, 4'b0110, 4'hF, '0, r);
    check("R9 trdy", r, 3'b010);
    check("R5 rdata held", ini_rdata, 32'hCAFE_1234);
    attempt(32'h1000_0040, 4'b0110, 4'hF, '0, r);
    check("R9 new request", {r, tgt_req}, 4'b0011);
    tevent(0, 32'h0, '0);
    attempt(32'h1000_0040, 4'b0110, 4'hF, '0, r);
    check("R9 second trdy", r, 3'b010);
  endtask

  task automatic t_mabort();
    logic [2:0] r;
    attempt(32'h0001_0800, 4'b1010, 4'hF, '0, r);
    check("R2 cfg retry", r, 3'b001);
    tevent(1, 32'h1234_5678, '0);
    check("R6 req drops", tgt_req, 0);
    attempt(32'h0001_0800, 4'b1010, 4'hF, '0, r);
    check("R6 trdy", r, 3'b010);
    check("R6 all ones", ini_rdata, 32'hFFFF_FFFF);
    check("R6 no abort status", sts, 0);
  endtask

  task automatic t_tabort();
    logic [2:0] r;
    attempt(32'h3000_0010, 4'b0111, 4'h1, 32'h55AA_55AA, r);
    check("R2 write retry", r, 3'b001);
    check("R2 tgt_wdata", tgt_wdata, 32'h55AA_55AA);
    tevent(2, '0, '0);
    check("R7 rx bit", sts, 3'b001);
    attempt(32'h3000_0010, 4'b0111, 4'h1, '0, r);
    check("R7 tabort resp", r, 3'b100);
    check("R7 sig bit", sts, 3'b011);
    clear_sts(3'b001);
    check("R11 clear one bit", sts, 3'b010);
    clear_sts(3'b010);
    check("R11 clear other", sts, 3'b000);
    attempt(32'h3000_0020, 4'b0111, 4'hF, '0, r);
    tevent(2, '0, 3'b001);
    check("R11 set wins", sts[0], 1);
    attempt(32'h3000_0020, 4'b0111, 4'hF, '0, r);
    check("R7 tabort again", r, 3'b100);
    clear_sts(3'b011);
    check("R11 cleared", sts, 0);
  endtask

  task automatic t_discard();
    logic [2:0] r;
    attempt(32'h4000_0000, 4'b0110, 4'hF, '0, r);
    tevent(0, 32'h0BAD_F00D, '0);
    for (int i = 0; i < (1 << DISC_W) - 1; i++) @(negedge clk);
    check("R10 not yet", sts[2], 0);
    @(negedge clk);
    check("R10 discard set", sts[2], 1);
    attempt(32'h4000_0000, 4'b0110, 4'hF, '0, r);
    check("R10 treated as new", {r, tgt_req}, 4'b0011);
    tevent(0, '0, '0);
    attempt(32'h4000_0000, 4'b0110, 4'hF, '0, r);
    check("R10 completes", r, 3'b010);
    clear_sts(3'b100);
    check("R11 discard cleared", sts, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_xfer();
    t_mabort();
    t_tabort();
    t_discard();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule